// File: doc/BRIEF.md
# Strided Multi-Loop Address Generator

This block turns one transfer record into the ordered list of burst start addresses for a data move of one to four nested loops. The innermost loop is a contiguous burst of `count0` bytes. Each of up to three outer loops adds its own signed 32-bit stride to a 64-bit running address. A record is offered with a valid/ready handshake. Bursts leave on a second valid/ready handshake. Each finished or refused record produces a one-cycle response that carries a status byte and the record's command tag.

Two trigger slots can hold back chosen loops until a pulse arrives on a selected trigger line. A progress pulse output marks loop iterations, and the record's event-size field chooses which loop it follows. The record type sets how many loops are live. A wait flag decides whether the next record may be taken while the response of the current one is still on the port.

Top module: `stride_agen`

## Requirements
- R1: Record type in flags[3:0] sets the live loops: 0 one loop, 1 two, 2 three, 3 four. Counts of loops that are not live are ignored. Every burst carries `burst_len` equal to `rec_cnt0`, and `burst_valid` never coexists with `rec_ready`.
- R2: Bursts run with the innermost outer loop fastest. The address is base + i1*stride1 + i2*stride2 + i3*stride3 with strides sign-extended, computed modulo 2^64.
- R3: A live outer count of zero is run as a single pass.
- R4: With event-size (flags[7:6]) 0, exactly one `evt_pulse` comes, in the cycle of the completion response.
- R5: With event-size k in 1..3 and type >= k, one `evt_pulse` follows each accepted burst that finishes an iteration of loop k. Loop 1 counts every burst.
- R6: With event-size k and type < k, one `evt_pulse` comes, with the last burst's completion.
- R7: Count0 of zero refuses the record. Status is 0x03 (type 3 in bits 3:0, info 0 in bits 7:4). No burst and no event are issued.
- R8: A type above 3 refuses the record with status 0x04. This check has priority over R7.
- R9: A normal finish reports status 0x00. `resp_valid` pulses one cycle after the last burst is accepted, or one cycle after a refused record is taken. `resp_cmd` echoes flags[23:16].
- R10: In the response cycle, `rec_ready` equals the inverse of the record's wait flag (flags[5]).
- R11: Slot 0 selector flags[9:8] and slot 1 selector flags[13:12] use the codes 0 none, 1 `trig_pulse[0]`, 2 `trig_pulse[1]`, 3 `trig_pulse[2]`. Their kinds flags[11:10] and flags[15:14] use 0/1/2 to gate loop 1/2/3. For a gated loop, each iteration waits for one pulse on the selected line, and pulses on other lines are ignored.
- R12: Kind 3 gates the whole record. One pulse before the first burst lets every burst run.
- R13: While `burst_ready` is low, `burst_valid`, `burst_addr` and `burst_len` hold.
- R14: After reset, `rec_ready` is 1 and `burst_valid`, `evt_pulse` and `resp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record can be taken |
| rec_flags | input | 24 | Type, wait, event size, trigger slots, command tag |
| rec_cnt0 | input | CNT_W | Burst length in bytes |
| rec_cnt1 | input | CNT_W | Loop 1 count |
| rec_cnt2 | input | CNT_W | Loop 2 count |
| rec_cnt3 | input | CNT_W | Loop 3 count |
| rec_base | input | ADDR_W | Start address |
| rec_stride1 | input | STRIDE_W | Signed loop 1 stride |
| rec_stride2 | input | STRIDE_W | Signed loop 2 stride |
| rec_stride3 | input | STRIDE_W | Signed loop 3 stride |
| trig_pulse | input | 3 | Trigger lines: global 0, global 1, local |
| burst_valid | output | 1 | Burst address valid |
| burst_ready | input | 1 | Burst accepted |
| burst_addr | output | ADDR_W | Burst start address |
| burst_len | output | CNT_W | Burst length |
| evt_pulse | output | 1 | Progress event |
| resp_valid | output | 1 | Response pulse |
| resp_status | output | 8 | Status byte |
| resp_cmd | output | 8 | Echoed command tag |

## Verification
A wrong loop index shows up at the first burst after the mistake, as a wrong address or a response that comes early or late. The bench checks every burst address against the closed-form sum, so it catches such an error within one burst. A wrong gating or credit state shows up as a burst that is issued or held back in the same cycle as the trigger that should have decided it, and the bench samples `burst_valid` there. Errors in the event and status state show up at the response, where the event count, status and tag are compared.

// File: rtl/sag_pkg.sv
`timescale 1ns/1ps
package sag_pkg;
  localparam int SAG_NLVL   = 3;   // outer loops
  localparam int SAG_FLAG_W = 24;
  localparam int SAG_NSLOT  = 2;
  localparam logic [7:0] SAG_ST_OK    = 8'h00;
  localparam logic [7:0] SAG_ST_SUBMIT = 8'h03;
  localparam logic [7:0] SAG_ST_UNSUP = 8'h04;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} sag_state_e;
endpackage

// File: rtl/sag_decode.sv
`timescale 1ns/1ps
module sag_decode import sag_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic [SAG_FLAG_W-1:0]          flags,
  input  logic [CNT_W-1:0]               cnt0,
  output logic                           err,
  output logic [7:0]                     err_status,
  output logic [1:0]                     dims,
  output logic [1:0]                     evsize,
  output logic                           hold,
  output logic [7:0]                     cmd,
  output logic [SAG_NSLOT-1:0][1:0]      tsel,
  output logic [SAG_NSLOT-1:0][1:0]      tkind
);
  logic unused_static;
  assign unused_static = flags[4];

  always_comb begin
    err        = 1'b0;
    err_status = SAG_ST_OK;
    if (flags[3:0] > 4'd3) begin
      err        = 1'b1;
      err_status = SAG_ST_UNSUP;
    end else if (cnt0 == '0) begin
      err        = 1'b1;
      err_status = SAG_ST_SUBMIT;
    end
  end

  assign dims   = flags[1:0];
  assign hold   = flags[5];
  assign evsize = flags[7:6];
  assign cmd    = flags[23:16];

  for (genvar s = 0; s < SAG_NSLOT; s++) begin : g_slot
    assign tsel[s]  = flags[8 + 4*s +: 2];
    assign tkind[s] = flags[10 + 4*s +: 2];
  end
endmodule

// File: rtl/sag_loops.sv
`timescale 1ns/1ps
module sag_loops #(
  parameter int CNT_W = 16,
  parameter int NLVL  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic [1:0]                 dims,
  input  logic [NLVL-1:0][CNT_W-1:0] cnt_in,
  input  logic                       fire,
  output logic [NLVL-1:0]            step_v,
  output logic [NLVL:0]              carry
);
  logic [NLVL-1:0][CNT_W-1:0] idx_q, lim_q;
  logic [NLVL-1:0]            last_v;

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign last_v[g]  = (idx_q[g] == lim_q[g]);
    assign carry[g+1] = carry[g] & last_v[g];
    assign step_v[g]  = fire & carry[g] & ~last_v[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[g] <= '0;
        lim_q[g] <= '0;
      end else if (load) begin
        idx_q[g] <= '0;
        lim_q[g] <= (dims > 2'(g) && cnt_in[g] != '0) ? cnt_in[g] - CNT_W'(1) : '0;
      end else if (fire) begin
        if (step_v[g])     idx_q[g] <= idx_q[g] + CNT_W'(1);
        else if (carry[g]) idx_q[g] <= '0;
      end
    end
  end
endmodule

// File: rtl/sag_trig_slot.sv
`timescale 1ns/1ps
module sag_trig_slot (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] sel_in,
  input  logic [1:0] kind_in,
  input  logic [2:0] trig,
  input  logic       fire,
  input  logic [3:0] step_ext,
  output logic       ok
);
  logic [1:0] sel_q, kind_q;
  logic       need_q, armed_q, line, hit;

  always_comb begin
    case (sel_q)
      2'd1:    line = trig[0];
      2'd2:    line = trig[1];
      2'd3:    line = trig[2];
      default: line = 1'b0;
    endcase
  end

  assign hit = (kind_q != 2'd3) && step_ext[kind_q];
  assign ok  = (sel_q == 2'd0) || !need_q || armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      kind_q  <= '0;
      need_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (start) begin
      sel_q   <= sel_in;
      kind_q  <= kind_in;
      need_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (fire) begin
      need_q  <= hit;
      armed_q <= need_q ? line : (armed_q | line);
    end else begin
      armed_q <= armed_q | line;
    end
  end
endmodule

// File: rtl/stride_agen.sv
`timescale 1ns/1ps
module stride_agen import sag_pkg::*; #(
  parameter int ADDR_W   = 64,
  parameter int CNT_W    = 16,
  parameter int STRIDE_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rec_valid,
  output logic                  rec_ready,
  input  logic [SAG_FLAG_W-1:0] rec_flags,
  input  logic [CNT_W-1:0]      rec_cnt0,
  input  logic [CNT_W-1:0]      rec_cnt1,
  input  logic [CNT_W-1:0]      rec_cnt2,
  input  logic [CNT_W-1:0]      rec_cnt3,
  input  logic [ADDR_W-1:0]     rec_base,
  input  logic [STRIDE_W-1:0]   rec_stride1,
  input  logic [STRIDE_W-1:0]   rec_stride2,
  input  logic [STRIDE_W-1:0]   rec_stride3,
  input  logic [2:0]            trig_pulse,
  output logic                  burst_valid,
  input  logic                  burst_ready,
  output logic [ADDR_W-1:0]     burst_addr,
  output logic [CNT_W-1:0]      burst_len,
  output logic                  evt_pulse,
  output logic                  resp_valid,
  output logic [7:0]            resp_status,
  output logic [7:0]            resp_cmd
);
  localparam int NLVL  = SAG_NLVL;
  localparam int LVL_W = $clog2(NLVL);

  sag_state_e state_q;
  logic accept, fire, done;

  // record decode
  logic                          dec_err, dec_hold;
  logic [7:0]                    dec_status, dec_cmd;
  logic [1:0]                    dec_dims, dec_es;
  logic [SAG_NSLOT-1:0][1:0]     dec_tsel, dec_tkind;

  sag_decode #(.CNT_W(CNT_W)) u_dec (
    .flags(rec_flags), .cnt0(rec_cnt0), .err(dec_err), .err_status(dec_status),
    .dims(dec_dims), .evsize(dec_es), .hold(dec_hold), .cmd(dec_cmd),
    .tsel(dec_tsel), .tkind(dec_tkind)
  );

  // loop counters
  logic [NLVL-1:0]            step_v;
  logic [NLVL:0]              carry;
  logic [NLVL-1:0][CNT_W-1:0] cnt_pack;
  assign cnt_pack = {rec_cnt3, rec_cnt2, rec_cnt1};

  sag_loops #(.CNT_W(CNT_W), .NLVL(NLVL)) u_loops (
    .clk(clk), .rst(rst), .load(accept), .dims(dec_dims), .cnt_in(cnt_pack),
    .fire(fire), .step_v(step_v), .carry(carry)
  );
  assign done = carry[NLVL];

  // trigger slots
  logic [SAG_NSLOT-1:0] slot_ok;
  for (genvar s = 0; s < SAG_NSLOT; s++) begin : g_trig
    sag_trig_slot u_slot (
      .clk(clk), .rst(rst), .start(accept && !dec_err),
      .sel_in(dec_tsel[s]), .kind_in(dec_tkind[s]), .trig(trig_pulse),
      .fire(fire), .step_ext({1'b0, step_v}), .ok(slot_ok[s])
    );
  end

  assign rec_ready   = (state_q == ST_IDLE) || (state_q == ST_DONE && !hold_q);
  assign burst_valid = (state_q == ST_RUN) && (&slot_ok);
  assign accept      = rec_valid && rec_ready;
  assign fire        = burst_valid && burst_ready;

  // address accumulators: a_q[0] is the live burst address
  logic                              hold_q;
  logic [1:0]                        dims_q, es_q;
  logic [7:0]                        cmd_q;
  logic [NLVL-1:0][STRIDE_W-1:0]     str_q;
  logic [NLVL-1:0][ADDR_W-1:0]       a_q, s_ext;
  logic [LVL_W-1:0]                  hi;
  logic [ADDR_W-1:0]                 a_next;
  logic                              ev_cond;

  for (genvar g = 0; g < NLVL; g++) begin : g_sext
    assign s_ext[g] = {{(ADDR_W-STRIDE_W){str_q[g][STRIDE_W-1]}}, str_q[g]};
  end

  always_comb begin
    hi = '0;
    for (int k = 0; k < NLVL; k++) if (step_v[k]) hi = LVL_W'(k);
    a_next = a_q[hi] + s_ext[hi];
  end

  always_comb begin
    if (es_q == 2'd0)        ev_cond = done;
    else if (dims_q >= es_q) ev_cond = carry[es_q - 2'd1];
    else                     ev_cond = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      str_q <= '0;
    end else if (accept) begin
      for (int j = 0; j < NLVL; j++) a_q[j] <= rec_base;
      str_q <= {rec_stride3, rec_stride2, rec_stride1};
    end else if (fire && (|step_v)) begin
      for (int j = 0; j < NLVL; j++) if (LVL_W'(j) <= hi) a_q[j] <= a_next;
    end
  end
  assign burst_addr = a_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      hold_q      <= 1'b0;
      dims_q      <= '0;
      es_q        <= '0;
      cmd_q       <= '0;
      burst_len   <= '0;
      evt_pulse   <= 1'b0;
      resp_valid  <= 1'b0;
      resp_status <= '0;
      resp_cmd    <= '0;
    end else begin
      evt_pulse  <= 1'b0;
      resp_valid <= 1'b0;
      if (accept) begin
        hold_q    <= dec_hold;
        dims_q    <= dec_dims;
        es_q      <= dec_es;
        cmd_q     <= dec_cmd;
        burst_len <= rec_cnt0;
        if (dec_err) begin
          state_q     <= ST_DONE;
          resp_valid  <= 1'b1;
          resp_status <= dec_status;
          resp_cmd    <= dec_cmd;
        end else begin
          state_q <= ST_RUN;
        end
      end else if (fire) begin
        evt_pulse <= ev_cond;
        if (done) begin
          state_q     <= ST_DONE;
          resp_valid  <= 1'b1;
          resp_status <= SAG_ST_OK;
          resp_cmd    <= cmd_q;
        end
      end else if (state_q == ST_DONE) begin
        state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/stride_agen_chk.sv
`timescale 1ns/1ps
module stride_agen_chk #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rec_ready,
  input logic              burst_valid,
  input logic              burst_ready,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [CNT_W-1:0]  burst_len,
  input logic              evt_pulse,
  input logic              resp_valid,
  input logic [7:0]        resp_status
);
  p_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (burst_valid && !burst_ready) |=>
      (burst_valid && $stable(burst_addr) && $stable(burst_len)));

  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> !rec_ready);

  p_nonzero_len_r7: assert property (@(posedge clk) disable iff (rst)
    burst_valid |-> (burst_len != '0));

  p_status_code_r8: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_status == 8'h00 || resp_status == 8'h03 || resp_status == 8'h04));

  p_evt_after_burst_r5: assert property (@(posedge clk) disable iff (rst)
    evt_pulse |-> $past(burst_valid && burst_ready));

  p_ok_after_burst_r9: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == 8'h00) |-> $past(burst_valid && burst_ready));
endmodule

bind stride_agen stride_agen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rec_ready(rec_ready), .burst_valid(burst_valid),
  .burst_ready(burst_ready), .burst_addr(burst_addr), .burst_len(burst_len),
  .evt_pulse(evt_pulse), .resp_valid(resp_valid), .resp_status(resp_status)
);

// File: tb/tb_stride_agen.sv
`timescale 1ns/1ps
module tb_stride_agen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [23:0] rec_flags = '0;
  logic [15:0] rec_cnt0 = '0, rec_cnt1 = '0, rec_cnt2 = '0, rec_cnt3 = '0;
  logic [63:0] rec_base = '0;
  logic [31:0] rec_stride1 = '0, rec_stride2 = '0, rec_stride3 = '0;
  logic [2:0]  trig_pulse = '0;
  logic        burst_valid;
  logic        burst_ready = 1'b1;
  logic [63:0] burst_addr;
  logic [15:0] burst_len;
  logic        evt_pulse, resp_valid;
  logic [7:0]  resp_status, resp_cmd;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  stride_agen dut (.*);

  typedef struct packed {
    logic [23:0] flags;
    logic [15:0] c0, c1, c2, c3;
    logic [63:0] base;
    logic [31:0] s1, s2, s3;
    logic [15:0] nb, ne;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{24'h110000, 16'd8, 16'd0, 16'd0, 16'd0, 64'h1000, 32'h0,  32'h0,        32'h0,        16'd1, 16'd1, 8'h00},
    '{24'h220061, 16'd4, 16'd3, 16'd0, 16'd0, 64'h2000, 32'h40, 32'h0,        32'h0,        16'd3, 16'd3, 8'h00},
    '{24'h330082, 16'd2, 16'd2, 16'd3, 16'd0, 64'h10,   32'h10, 32'hFFFFFF00, 32'h0,        16'd6, 16'd3, 8'h00},
    '{24'h4400E3, 16'd1, 16'd2, 16'd2, 16'd2, 64'h100,  32'h4,  32'h20,       32'hFFFFFC00, 16'd8, 16'd2, 8'h00},
    '{24'h5500C1, 16'd3, 16'd3, 16'd0, 16'd0, 64'h800,  32'h8,  32'h0,        32'h0,        16'd3, 16'd1, 8'h00},
    '{24'h660005, 16'd0, 16'd0, 16'd0, 16'd0, 64'h0,    32'h0,  32'h0,        32'h0,        16'd0, 16'd0, 8'h04},
    '{24'h770022, 16'd0, 16'd2, 16'd2, 16'd0, 64'h0,    32'h0,  32'h0,        32'h0,        16'd0, 16'd0, 8'h03},
    '{24'h880080, 16'd5, 16'd5, 16'd0, 16'd0, 64'hA000, 32'h100,32'h0,        32'h0,        16'd1, 16'd1, 8'h00},
    '{24'h990042, 16'd6, 16'd0, 16'd2, 16'd0, 64'hB000, 32'h40, 32'h100,      32'h0,        16'd2, 16'd2, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] s);
    return {{32{s[31]}}, s};
  endfunction

  // closed-form address of burst number b
  function automatic logic [63:0] exp_addr(input vec_t v, input int b);
    int t, e1, e2, i1, i2, i3;
    t  = int'(v.flags[3:0]);
    e1 = (t >= 1 && v.c1 != 0) ? int'(v.c1) : 1;
    e2 = (t >= 2 && v.c2 != 0) ? int'(v.c2) : 1;
    i1 = b % e1;
    i2 = (b / e1) % e2;
    i3 = b / (e1 * e2);
    return v.base + 64'(i1) * sx(v.s1) + 64'(i2) * sx(v.s2) + 64'(i3) * sx(v.s3);
  endfunction

  task automatic drive(input vec_t v);
    rec_flags = v.flags; rec_cnt0 = v.c0; rec_cnt1 = v.c1; rec_cnt2 = v.c2; rec_cnt3 = v.c3;
    rec_base = v.base; rec_stride1 = v.s1; rec_stride2 = v.s2; rec_stride3 = v.s3;
  endtask

  task automatic offer(input vec_t v);
    int guard;
    @(negedge clk);
    drive(v);
    rec_valid = 1'b1;
    guard = 0;
    while (!rec_ready && guard < 50) begin @(negedge clk); guard++; end
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int nb, ne, guard, t, es;
    bit got;
    string etag, stag, btag;
    t  = int'(v.flags[3:0]);
    es = int'(v.flags[7:6]);
    etag = (es == 0) ? "R4" : ((t >= es) ? "R5" : "R6");
    stag = (v.st == 8'h04) ? "R8" : ((v.st == 8'h03) ? "R7" : "R9");
    btag = (t >= 1 && v.c1 == 0) || (t >= 2 && v.c2 == 0) ? "R3" : "R1";
    offer(v);
    nb = 0; ne = 0; got = 0; guard = 0;
    while (!got && guard < 500) begin
      if (evt_pulse) ne++;
      if (resp_valid) begin
        got = 1;
        chk(stag, 64'(resp_status), 64'(v.st));
        chk("R9 cmd", 64'(resp_cmd), 64'(v.flags[23:16]));
        chk("R10", 64'(rec_ready), 64'(!v.flags[5]));
      end else if (burst_valid) begin
        chk("R2 addr", burst_addr, exp_addr(v, nb));
        chk("R1 len", 64'(burst_len), 64'(v.c0));
        nb++;
      end
      if (!got) @(negedge clk);
      guard++;
    end
    chk("R9 response seen", 64'(got), 64'd1);
    chk(btag, 64'(nb), 64'(v.nb));
    chk(etag, 64'(ne), 64'(v.ne));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t tv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R14 rec_ready", 64'(rec_ready), 64'd1);
    chk("R14 burst_valid", 64'(burst_valid), 64'd0);
    chk("R14 evt_pulse", 64'(evt_pulse), 64'd0);
    chk("R14 resp_valid", 64'(resp_valid), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: slot 0 on global 0, gating loop 1
    tv = '{24'hA00141, 16'd4, 16'd2, 16'd0, 16'd0, 64'h3000, 32'h10, 32'h0, 32'h0, 16'd2, 16'd2, 8'h00};
    offer(tv);
    repeat (3) @(negedge clk);
    chk("R11 stall before pulse", 64'(burst_valid), 64'd0);
    trig_pulse = 3'b010;
    @(negedge clk); trig_pulse = 3'b000;
    @(negedge clk);
    chk("R11 other line ignored", 64'(burst_valid), 64'd0);
    trig_pulse = 3'b001;
    @(negedge clk); trig_pulse = 3'b000;
    chk("R11 released", 64'(burst_valid), 64'd1);
    chk("R11 addr0", burst_addr, 64'h3000);
    @(negedge clk);
    chk("R11 stall next iteration", 64'(burst_valid), 64'd0);
    trig_pulse = 3'b001;
    @(negedge clk); trig_pulse = 3'b000;
    chk("R11 released again", 64'(burst_valid), 64'd1);
    chk("R11 addr1", burst_addr, 64'h3010);
    @(negedge clk);
    chk("R11 response", 64'(resp_valid), 64'd1);

    // R12: slot 1 on local event, whole record
    tv = '{24'hB0F001, 16'd2, 16'd3, 16'd0, 16'd0, 64'h4000, 32'h8, 32'h0, 32'h0, 16'd3, 16'd1, 8'h00};
    offer(tv);
    repeat (2) @(negedge clk);
    chk("R12 stall", 64'(burst_valid), 64'd0);
    trig_pulse = 3'b100;
    @(negedge clk); trig_pulse = 3'b000;
    for (int k = 0; k < 3; k++) begin
      chk("R12 free run", 64'(burst_valid), 64'd1);
      chk("R12 addr", burst_addr, 64'h4000 + 64'(8 * k));
      @(negedge clk);
    end
    chk("R12 response", 64'(resp_valid), 64'd1);

    // R13: backpressure holds the burst
    burst_ready = 1'b0;
    tv = '{24'hC00000, 16'd8, 16'd0, 16'd0, 16'd0, 64'h5000, 32'h0, 32'h0, 32'h0, 16'd1, 16'd1, 8'h00};
    offer(tv);
    for (int k = 0; k < 3; k++) begin
      chk("R13 valid held", 64'(burst_valid), 64'd1);
      chk("R13 addr held", burst_addr, 64'h5000);
      @(negedge clk);
    end
    burst_ready = 1'b1;
    @(negedge clk);
    chk("R13 response after release", 64'(resp_valid), 64'd1);

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule